// File: doc/BRIEF.md
# Luma and RGB Gain Stage

This block scales a stream of 4:4:4 pixels carrying three 10-bit components. A per-pixel mode bit says how the components are read. In YCbCr mode, component 0 is luma. It is scaled about the black level by one of sixteen fixed factors, picked by a 4-bit level code. The two chroma components pass through untouched. In RGB mode each colour channel has its own 8-bit gain, worth code/128, so the range runs from zero to just under double.

The mode, the level code and the three gains are sampled together with each pixel, so a change takes effect on exactly the pixel it arrives with. Every output is rounded to nearest and clamped to the 10-bit range. All components, the valid strobe and the sync flags come out exactly two clocks after they went in.

Top module: `pix_gain_adjust`

## Requirements
- R1: `out_valid` and `out_sync` equal `in_valid` and `in_sync` from two clock edges earlier, and every output component has the same two-edge latency.
- R2: When `rgb_mode` is 0, `out_c0 = 64 + floor(((in_c0 - 64) * (25 + luma_code) + 16) / 32)`, clamped to 0..1023. This means an input of exactly 64 always stays 64.
- R3: Level code 0 gives a factor of 25/32 (78.125%), code 15 gives 40/32 (125%), and code 7 leaves luma unchanged.
- R4: When `rgb_mode` is 0, `out_c1` and `out_c2` equal `in_c1` and `in_c2` unchanged.
- R5: When `rgb_mode` is 1, each component becomes `floor((x * gain + 64) / 128)`, with independent gains. Component 0 (G) uses `gain_g`, component 1 (B) uses `gain_b` and component 2 (R) uses `gain_r`.
- R6: An RGB gain of 128 passes its component unchanged, and a gain of 0 forces it to 0.
- R7: Any result above 1023 saturates to 1023, in both modes.
- R8: A luma result below 0 saturates to 0.
- R9: While `rst_n` is low at a clock edge, all outputs are cleared to 0, whatever the inputs are.
- R10: `luma_code` has no effect in RGB mode, and the three RGB gains have no effect in YCbCr mode.
- R11: The mode and all gain inputs are applied per pixel, so a change between back-to-back pixels affects only the later pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel strobe |
| in_sync | input | 3 | Sync flags travelling with the pixel |
| rgb_mode | input | 1 | 0: YCbCr components, 1: RGB components |
| luma_code | input | 4 | Luma level code, factor (25+code)/32 |
| gain_r | input | 8 | Red gain, code/128 |
| gain_g | input | 8 | Green gain, code/128 |
| gain_b | input | 8 | Blue gain, code/128 |
| in_c0 | input | 10 | Y or G component |
| in_c1 | input | 10 | Cb or B component |
| in_c2 | input | 10 | Cr or R component |
| out_valid | output | 1 | Delayed strobe |
| out_sync | output | 3 | Delayed sync flags |
| out_c0 | output | 10 | Scaled Y or G |
| out_c1 | output | 10 | Cb passed through, or scaled B |
| out_c2 | output | 10 | Cr passed through, or scaled R |

## Verification
Assertions check several properties on every cycle:
- the two-edge alignment of strobe and sync;
- chroma passing through in YCbCr mode;
- the fixed points of each lane: level code 7 and a black input for luma, and gains 0 and 128 for RGB.

The arithmetic at other codes depends on the data and is only shown by the bench's scenarios. These cover the rounding direction for negative luma offsets, saturation at both ends, independent per-channel gains, settings that must be ignored, and mode switches between adjacent pixels.

// File: rtl/pix_gain_pkg.sv
// Shared constants and types for the gain stage.
// Assumes components are unsigned codes and the black level lies inside the range.
package pix_gain_pkg;
    localparam int unsigned PG_COMP_W     = 10;  // bits per component
    localparam int unsigned PG_LCODE_W    = 4;   // luma level code width
    localparam int unsigned PG_GAIN_W     = 8;   // RGB gain code width
    localparam int unsigned PG_SYNC_W     = 3;   // sync flags carried along
    localparam int unsigned PG_LUMA_BASE  = 25;  // luma factor numerator offset
    localparam int unsigned PG_LUMA_SHIFT = 5;   // luma factor denominator log2
    localparam int unsigned PG_BLACK      = 64;  // luma black level
    localparam int unsigned PG_RGB_SHIFT  = 7;   // RGB gain denominator log2

    typedef enum logic {
        PG_MODE_YCC = 1'b0,
        PG_MODE_RGB = 1'b1
    } pg_mode_e;
endpackage

// File: rtl/pix_delay.sv
// Fixed-length register chain for side-band data.
// Assumes STAGES >= 1; every stage clears on synchronous active-low reset.
module pix_delay #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the chain by one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/luma_scale_lane.sv
// Luma lane: registers (y - black) * (BASE + code), then rounds, re-adds
// black and clamps combinationally. Assumes BASE + 2**CODE_W fits the gain width.
module luma_scale_lane #(
    parameter int unsigned COMP_W = 10,
    parameter int unsigned CODE_W = 4,
    parameter int unsigned BASE   = 25,
    parameter int unsigned SHIFT  = 5,
    parameter int unsigned BLACK  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COMP_W-1:0] px_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [COMP_W-1:0] px_o
);
    localparam int unsigned GW    = $clog2(BASE + (1 << CODE_W));
    localparam int unsigned DW    = COMP_W + 1;
    localparam int unsigned PW    = DW + GW + 1;
    localparam int unsigned UNITY = (1 << SHIFT) - BASE;
    localparam logic signed [PW-1:0] HALF = PW'(1 << (SHIFT - 1));
    localparam logic signed [PW-1:0] BLK  = PW'(BLACK);
    localparam logic signed [PW-1:0] TOPV = PW'((1 << COMP_W) - 1);

    logic signed [DW-1:0] diff;
    logic signed [GW:0]   gain_s;
    logic signed [PW-1:0] prod_c;
    logic signed [PW-1:0] prod_q;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] lvl;

    // Offset from black and signed multiply by the level factor.
    always_comb begin
        diff   = $signed({1'b0, px_i}) - $signed(DW'(BLACK));
        gain_s = $signed({1'b0, GW'(BASE) + GW'(code_i)});
        prod_c = PW'(diff) * PW'(gain_s);
    end

    // Stage-one product register.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_c;
    end

    // Round half up, restore black level, clamp to the component range.
    always_comb begin
        rnd = (prod_q + HALF) >>> SHIFT;
        lvl = rnd + BLK;
        if (lvl < 0)         px_o = '0;
        else if (lvl > TOPV) px_o = '1;
        else                 px_o = lvl[COMP_W-1:0];
    end

    AST_LUMA_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(code_i) == CODE_W'(UNITY)) |-> px_o == $past(px_i)); // R3
    AST_LUMA_BLACK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(px_i) == COMP_W'(BLACK)) |-> px_o == COMP_W'(BLACK)); // R2
endmodule

// File: rtl/rgb_scale_lane.sv
// One colour lane: registers x * gain, then rounds by 2**SHIFT and clamps.
// Assumes the unity gain 2**SHIFT is representable in GAIN_W bits.
module rgb_scale_lane #(
    parameter int unsigned COMP_W = 10,
    parameter int unsigned GAIN_W = 8,
    parameter int unsigned SHIFT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COMP_W-1:0] px_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic [COMP_W-1:0] px_o
);
    localparam int unsigned PW = COMP_W + GAIN_W;
    localparam logic [PW:0] HALF = (PW+1)'(1 << (SHIFT - 1));
    localparam logic [PW:0] TOPV = (PW+1)'((1 << COMP_W) - 1);

    logic [PW-1:0] prod_q;
    logic [PW:0]   sum;
    logic [PW:0]   shifted;

    // Stage-one product register.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= px_i * gain_i;
    end

    // Round half up and clamp at full scale.
    always_comb begin
        sum     = {1'b0, prod_q} + HALF;
        shifted = sum >> SHIFT;
        if (shifted > TOPV) px_o = '1;
        else                px_o = shifted[COMP_W-1:0];
    end

    AST_RGB_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gain_i) == '0) |-> px_o == '0); // R6
    AST_RGB_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gain_i) == GAIN_W'(1 << SHIFT)) |-> px_o == $past(px_i)); // R6
endmodule

// File: rtl/pix_gain_adjust.sv
// Top of the gain stage: one luma lane, three RGB lanes and a side-band delay
// feed a common output register, giving a two-clock latency on every path.
// Assumes mode and gains are valid on the same cycle as their pixel.
module pix_gain_adjust
    import pix_gain_pkg::*;
#(
    parameter int unsigned COMP_W  = PG_COMP_W,
    parameter int unsigned LCODE_W = PG_LCODE_W,
    parameter int unsigned GAIN_W  = PG_GAIN_W,
    parameter int unsigned SYNC_W  = PG_SYNC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [SYNC_W-1:0]  in_sync,
    input  logic               rgb_mode,
    input  logic [LCODE_W-1:0] luma_code,
    input  logic [GAIN_W-1:0]  gain_r,
    input  logic [GAIN_W-1:0]  gain_g,
    input  logic [GAIN_W-1:0]  gain_b,
    input  logic [COMP_W-1:0]  in_c0,
    input  logic [COMP_W-1:0]  in_c1,
    input  logic [COMP_W-1:0]  in_c2,
    output logic               out_valid,
    output logic [SYNC_W-1:0]  out_sync,
    output logic [COMP_W-1:0]  out_c0,
    output logic [COMP_W-1:0]  out_c1,
    output logic [COMP_W-1:0]  out_c2
);
    localparam int unsigned NCH  = 3;
    localparam int unsigned SB_W = 1 + SYNC_W + 1 + 2 * COMP_W;

    logic [COMP_W-1:0] comp_in  [NCH];
    logic [GAIN_W-1:0] gain_in  [NCH];
    logic [COMP_W-1:0] rgb_res  [NCH];
    logic [COMP_W-1:0] luma_res;

    logic [SB_W-1:0]   sb_d;
    logic [SB_W-1:0]   sb_q;
    logic              valid_q;
    logic [SYNC_W-1:0] sync_q;
    pg_mode_e          mode_q;
    logic [COMP_W-1:0] c1_q;
    logic [COMP_W-1:0] c2_q;

    assign comp_in[0] = in_c0;
    assign comp_in[1] = in_c1;
    assign comp_in[2] = in_c2;
    assign gain_in[0] = gain_g;
    assign gain_in[1] = gain_b;
    assign gain_in[2] = gain_r;

    luma_scale_lane #(
        .COMP_W (COMP_W),
        .CODE_W (LCODE_W),
        .BASE   (PG_LUMA_BASE),
        .SHIFT  (PG_LUMA_SHIFT),
        .BLACK  (PG_BLACK)
    ) i_luma (
        .clk    (clk),
        .rst_n  (rst_n),
        .px_i   (in_c0),
        .code_i (luma_code),
        .px_o   (luma_res)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_rgb
        rgb_scale_lane #(
            .COMP_W (COMP_W),
            .GAIN_W (GAIN_W),
            .SHIFT  (PG_RGB_SHIFT)
        ) i_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .px_i   (comp_in[ch]),
            .gain_i (gain_in[ch]),
            .px_o   (rgb_res[ch])
        );
    end

    assign sb_d = {in_valid, in_sync, rgb_mode, in_c1, in_c2};

    pix_delay #(
        .W      (SB_W),
        .STAGES (1)
    ) i_sideband (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sb_d),
        .q     (sb_q)
    );

    // Unpack the delayed side-band bundle.
    always_comb begin
        {valid_q, sync_q} = sb_q[SB_W-1 -: 1+SYNC_W];
        mode_q            = pg_mode_e'(sb_q[2*COMP_W]);
        c1_q              = sb_q[2*COMP_W-1 -: COMP_W];
        c2_q              = sb_q[COMP_W-1:0];
    end

    // Stage-two output register: pick scaled or passed components per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sync  <= '0;
            out_c0    <= '0;
            out_c1    <= '0;
            out_c2    <= '0;
        end else begin
            out_valid <= valid_q;
            out_sync  <= sync_q;
            if (mode_q == PG_MODE_RGB) begin
                out_c0 <= rgb_res[0];
                out_c1 <= rgb_res[1];
                out_c2 <= rgb_res[2];
            end else begin
                out_c0 <= luma_res;
                out_c1 <= c1_q;
                out_c2 <= c2_q;
            end
        end
    end

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |->
        (out_valid == $past(in_valid, 2) && out_sync == $past(in_sync, 2))); // R1
    AST_CHROMA_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(rgb_mode, 2)) |->
        (out_c1 == $past(in_c1, 2) && out_c2 == $past(in_c2, 2))); // R4
endmodule

// File: tb/test_pix_gain_adjust.sv
// Scoreboard bench: the driver queues a model result per pixel, the monitor
// compares each result in the cycle it is due at the outputs.
module test_pix_gain_adjust;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_sync = '0;
    logic       rgb_mode = 1'b0;
    logic [3:0] luma_code = '0;
    logic [7:0] gain_r = '0, gain_g = '0, gain_b = '0;
    logic [9:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic       out_valid;
    logic [2:0] out_sync;
    logic [9:0] out_c0, out_c1, out_c2;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic       v;
        logic [2:0] s;
        logic [9:0] c0, c1, c2;
        int         due;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    pix_gain_adjust i_pix_gain_adjust (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .rgb_mode(rgb_mode), .luma_code(luma_code),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_sync(out_sync),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [9:0] clamp10(int v);
        if (v < 0) return 10'd0;
        if (v > 1023) return 10'd1023;
        return 10'(v);
    endfunction

    function automatic logic [9:0] m_luma(logic [9:0] y, logic [3:0] code);
        int p;
        p = (int'(y) - 64) * (25 + int'(code));
        p = ((p + 16) >>> 5) + 64;
        return clamp10(p);
    endfunction

    function automatic logic [9:0] m_rgb(logic [9:0] x, logic [7:0] g);
        return clamp10((int'(x) * int'(g) + 64) >>> 7);
    endfunction

    task automatic drive(input logic v, input logic [2:0] s, input logic mode,
                         input logic [3:0] code, input logic [7:0] gr,
                         input logic [7:0] gg, input logic [7:0] gb,
                         input logic [9:0] c0, input logic [9:0] c1,
                         input logic [9:0] c2, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        in_valid = v; in_sync = s; rgb_mode = mode; luma_code = code;
        gain_r = gr; gain_g = gg; gain_b = gb;
        in_c0 = c0; in_c1 = c1; in_c2 = c2;
        e.v = v; e.s = s; e.req = req; e.due = cyc + 2;
        if (mode) begin
            e.c0 = m_rgb(c0, gg); e.c1 = m_rgb(c1, gb); e.c2 = m_rgb(c2, gr);
        end else begin
            e.c0 = m_luma(c0, code); e.c1 = c1; e.c2 = c2;
        end
        sb_q.push_back(e);
    endtask

    // Monitor: pop and compare every item due this cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (out_valid !== e.v || out_sync !== e.s || out_c0 !== e.c0 ||
                out_c1 !== e.c1 || out_c2 !== e.c2) begin
                errors++;
                $display("FAIL %s: got v=%0b s=%0d c=%0d/%0d/%0d exp v=%0b s=%0d c=%0d/%0d/%0d",
                         e.req, out_valid, out_sync, out_c0, out_c1, out_c2,
                         e.v, e.s, e.c0, e.c1, e.c2);
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            summary();
        end
    end

    initial begin
        // R9: reset clears outputs even with busy inputs.
        in_valid = 1'b1; in_sync = 3'b101; rgb_mode = 1'b1;
        gain_r = 8'd200; gain_g = 8'd200; gain_b = 8'd200;
        in_c0 = 10'd500; in_c1 = 10'd600; in_c2 = 10'd700;
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sync !== 3'd0 || out_c0 !== 10'd0 ||
            out_c1 !== 10'd0 || out_c2 !== 10'd0) begin
            errors++;
            $display("FAIL R9: got v=%0b s=%0d c=%0d/%0d/%0d exp all 0",
                     out_valid, out_sync, out_c0, out_c1, out_c2);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R3: end points and unity of the luma table.
        drive(1, 3'd1, 0, 4'd0,  8'd0, 8'd0, 8'd0, 10'd384, 10'd512, 10'd512, "R3");
        drive(1, 3'd2, 0, 4'd15, 8'd0, 8'd0, 8'd0, 10'd384, 10'd512, 10'd512, "R3");
        drive(1, 3'd3, 0, 4'd7,  8'd0, 8'd0, 8'd0, 10'd777, 10'd512, 10'd512, "R3");

        // R2 and R4: every code on several luma levels, chroma varies.
        for (int c = 0; c < 16; c++) begin
            drive(1, 3'(c), 0, 4'(c), 8'd9, 8'd9, 8'd9, 10'd64,  10'(c*60), 10'(1023-c*50), "R2");
            drive(1, 3'(c), 0, 4'(c), 8'd9, 8'd9, 8'd9, 10'd101, 10'(c*7),  10'(c*33), "R4");
            drive(0, 3'(c), 0, 4'(c), 8'd9, 8'd9, 8'd9, 10'd940, 10'd3,     10'd1020, "R2");
        end

        // R8 and R2: below-black rounding and low clamp.
        drive(1, 3'd0, 0, 4'd15, 8'd0, 8'd0, 8'd0, 10'd0,  10'd1, 10'd2, "R8");
        drive(1, 3'd0, 0, 4'd0,  8'd0, 8'd0, 8'd0, 10'd10, 10'd1, 10'd2, "R2");
        drive(1, 3'd0, 0, 4'd3,  8'd0, 8'd0, 8'd0, 10'd63, 10'd1, 10'd2, "R2");

        // R7: high saturation in both modes.
        drive(1, 3'd4, 0, 4'd15, 8'd0,   8'd0,   8'd0,   10'd1023, 10'd0, 10'd0, "R7");
        drive(1, 3'd4, 1, 4'd0,  8'd255, 8'd255, 8'd255, 10'd1023, 10'd700, 10'd513, "R7");

        // R6: gain 0 and gain 128.
        drive(1, 3'd5, 1, 4'd3, 8'd0,   8'd128, 8'd0,   10'd333, 10'd444, 10'd555, "R6");
        drive(1, 3'd5, 1, 4'd3, 8'd128, 8'd0,   8'd128, 10'd1023, 10'd1, 10'd999, "R6");

        // R5: independent channel gains.
        drive(1, 3'd6, 1, 4'd0, 8'd64,  8'd200, 8'd1,   10'd300, 10'd301, 10'd302, "R5");
        drive(1, 3'd6, 1, 4'd0, 8'd191, 8'd17,  8'd129, 10'd511, 10'd127, 10'd1000, "R5");

        // R10: ignored settings in each mode.
        for (int k = 0; k < 16; k++) begin
            drive(1, 3'd7, 1, 4'(k), 8'd90, 8'd150, 8'd30, 10'd400, 10'd400, 10'd400, "R10");
            drive(1, 3'd7, 0, 4'd9, 8'(k*16), 8'(255-k), 8'(k), 10'd400, 10'd400, 10'd400, "R10");
        end

        // R11 and R1: random back-to-back pixels with mode and strobe toggling.
        for (int n = 0; n < 400; n++) begin
            drive(1'($urandom), 3'($urandom), 1'($urandom), 4'($urandom),
                  8'($urandom), 8'($urandom), 8'($urandom),
                  10'($urandom), 10'($urandom), 10'($urandom), "R11");
        end
        for (int n = 0; n < 40; n++) begin
            drive(1'(n % 3 == 0), 3'(n), 1'(n % 2), 4'(n), 8'(n*6), 8'(n*5), 8'(n*4),
                  10'(n*25), 10'(n*20), 10'(n*15), "R1");
        end

        while (sb_q.size() != 0) @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule